// File: doc/BRIEF.md
# Split-Pointer Circular Frame Queue Controller

This block keeps the bookkeeping for a circular buffer of 32-byte frame slots whose length is a power of two. It does not hold any data. It tracks four slot pointers. On the write side there is a committed pointer and an allocated pointer. On the read side there is a discarded pointer and a peeked pointer. The block hands back the slot offsets where data should be moved, and it publishes four occupancy counts.

Bulk transfers move a pointer pair together, one frame at a time. The split operations work in steps of 16 slots, one multiframe. They let a producer reserve space and fill it out of band before committing it. They let a consumer look at data before releasing it. A flush drops all unread data back to the last multiframe boundary at or below the committed pointer.

The block accepts one operation per clock, presented on `op_valid` and `op_code`. Its response comes out on the following cycle.

Top module: `frame_ring_ctl`

## Requirements
- R1: After reset all four pointers are zero, the base is 0 and the length is 2**DEF_LG (128 by default). The counts are therefore free = length-1 and valid = unseen = allocated = 0.
- R2: The counts are registered and change on the clock edge that accepts an operation. With M = length-1: free = (discarded-allocated-1)&M, valid = (committed-discarded)&M, unseen = (committed-peeked)&M, allocated = (allocated-discarded)&M.
- R3: Bulk write (op_code 2) grants the smallest of three values: req_cnt, the free count, and the slots left from the committed pointer to the end of the buffer. It returns the base plus the committed pointer as the offset. It sets both write pointers to committed+grant, masked.
- R4: Bulk read (op_code 3) grants the smallest of three values: req_cnt, the unseen count, and the slots left from the peeked pointer to the end of the buffer. It returns the base plus the peeked pointer. It sets both read pointers to peeked+grant, masked. A grant of 0 is not a failure.
- R5: Reserve (op_code 4) needs at least 16 free slots. On success it returns the base plus the allocated pointer and a grant of 16, and it advances only the allocated pointer by 16.
- R6: Commit (op_code 5) advances only the committed pointer by 16.
- R7: Peek (op_code 6) needs at least 16 unseen slots. On success it returns the base plus the peeked pointer and a grant of 16, and it advances only the peeked pointer by 16.
- R8: Discard (op_code 7) advances only the discarded pointer by 16.
- R9: Flush (op_code 1) sets both read pointers to the committed pointer with its low 4 bits cleared.
- R10: A reserve or peek that lacks room leaves every pointer unchanged. It raises rsp_fail together with rsp_valid for exactly the one cycle after the request, with a grant of 0.
- R11: Init (op_code 0) loads the base from cfg_base and the length 2**cfg_lg, where cfg_lg is between 4 and LOG_MAX. It zeroes all four pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request this cycle |
| op_code | input | 3 | Operation select (see requirements) |
| req_cnt | input | LOG_MAX+1 | Requested frame count for bulk operations |
| cfg_base | input | BASE_W | Base slot offset loaded by init |
| cfg_lg | input | LGW | log2 of the length loaded by init |
| rsp_valid | output | 1 | Response for the operation of the previous cycle |
| rsp_fail | output | 1 | Reserve or peek refused |
| rsp_ofs | output | BASE_W | Slot offset granted to the caller |
| rsp_cnt | output | LOG_MAX+1 | Frames granted |
| free_cnt | output | LOG_MAX | Unallocated slots |
| valid_cnt | output | LOG_MAX | Committed, not yet discarded slots |
| unseen_cnt | output | LOG_MAX | Committed, not yet peeked slots |
| alloc_cnt | output | LOG_MAX | Allocated, not yet discarded slots |

## Verification
Any pointer that goes wrong shows up in at least one of the four counts on the cycle after the faulty operation. A pointer that moves too far or moves when it should not therefore cannot stay hidden. A wrong read or write pointer also shows up in rsp_ofs the next time that side is used. The bench sets up states in which the clip at the wrap point, the clip at the free or unseen count, and the 16-slot threshold each decide the result. A flush is placed after a bulk read, so that the read pointers visibly move backwards.

// File: rtl/frame_ring_ctl.sv
module frame_ring_ctl #(
  parameter int LOG_MAX = 10,
  parameter int DEF_LG  = 7,
  parameter int BASE_W  = 16,
  parameter int LGW     = $clog2(LOG_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [2:0]         op_code,
  input  logic [LOG_MAX:0]   req_cnt,
  input  logic [BASE_W-1:0]  cfg_base,
  input  logic [LGW-1:0]     cfg_lg,
  output logic               rsp_valid,
  output logic               rsp_fail,
  output logic [BASE_W-1:0]  rsp_ofs,
  output logic [LOG_MAX:0]   rsp_cnt,
  output logic [LOG_MAX-1:0] free_cnt,
  output logic [LOG_MAX-1:0] valid_cnt,
  output logic [LOG_MAX-1:0] unseen_cnt,
  output logic [LOG_MAX-1:0] alloc_cnt
);
  localparam int PW = LOG_MAX;
  localparam logic [PW-1:0] MF = PW'(16);
  localparam logic [PW-1:0] DEF_MASK = PW'((1 << DEF_LG) - 1);

  localparam logic [2:0] OP_INIT = 3'd0, OP_FLUSH = 3'd1, OP_WR = 3'd2, OP_RD = 3'd3,
                         OP_RSV = 3'd4, OP_CMT = 3'd5, OP_PEEK = 3'd6, OP_DISC = 3'd7;

  logic [BASE_W-1:0] base, n_base;
  logic [PW-1:0] mask, n_mask;
  logic [PW-1:0] wc, wa, rd, rp, n_wc, n_wa, n_rd, n_rp;
  logic          n_fail;
  logic [BASE_W-1:0] n_ofs;
  logic [PW:0]   n_cnt;

  logic [PW-1:0] cur_free, cur_unseen;
  logic [PW:0]   wr_edge, rd_edge, wr_grant, rd_grant;

  assign cur_free   = (rd - wa - PW'(1)) & mask;
  assign cur_unseen = (wc - rp) & mask;
  assign wr_edge    = {1'b0, mask} - {1'b0, wc} + (PW+1)'(1);
  assign rd_edge    = {1'b0, mask} - {1'b0, rp} + (PW+1)'(1);

  function automatic logic [PW:0] min3(input logic [PW:0] a, input logic [PW:0] b,
                                       input logic [PW:0] c);
    logic [PW:0] m;
    m = (a < b) ? a : b;
    return (m < c) ? m : c;
  endfunction

  assign wr_grant = min3(req_cnt, wr_edge, {1'b0, cur_free});
  assign rd_grant = min3(req_cnt, rd_edge, {1'b0, cur_unseen});

  always_comb begin
    n_base = base; n_mask = mask;
    n_wc = wc; n_wa = wa; n_rd = rd; n_rp = rp;
    n_fail = 1'b0; n_ofs = '0; n_cnt = '0;
    if (op_valid) begin
      case (op_code)
        OP_INIT: begin
          n_base = cfg_base;
          n_mask = PW'((1 << cfg_lg) - 1);
          n_wc = '0; n_wa = '0; n_rd = '0; n_rp = '0;
        end
        OP_FLUSH: begin
          n_rd = wc & ~PW'(15);
          n_rp = wc & ~PW'(15);
        end
        OP_WR: begin
          n_ofs = base + BASE_W'(wc);
          n_cnt = wr_grant;
          n_wc  = (wc + wr_grant[PW-1:0]) & mask;
          n_wa  = (wc + wr_grant[PW-1:0]) & mask;
        end
        OP_RD: begin
          n_ofs = base + BASE_W'(rp);
          n_cnt = rd_grant;
          n_rd  = (rp + rd_grant[PW-1:0]) & mask;
          n_rp  = (rp + rd_grant[PW-1:0]) & mask;
        end
        OP_RSV: begin
          if (cur_free >= MF) begin
            n_ofs = base + BASE_W'(wa);
            n_cnt = (PW+1)'(16);
            n_wa  = (wa + MF) & mask;
          end else n_fail = 1'b1;
        end
        OP_CMT: begin
          n_cnt = (PW+1)'(16);
          n_wc  = (wc + MF) & mask;
        end
        OP_PEEK: begin
          if (cur_unseen >= MF) begin
            n_ofs = base + BASE_W'(rp);
            n_cnt = (PW+1)'(16);
            n_rp  = (rp + MF) & mask;
          end else n_fail = 1'b1;
        end
        default: begin
          n_cnt = (PW+1)'(16);
          n_rd  = (rd + MF) & mask;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= '0; mask <= DEF_MASK;
      wc <= '0; wa <= '0; rd <= '0; rp <= '0;
      rsp_valid <= 1'b0; rsp_fail <= 1'b0; rsp_ofs <= '0; rsp_cnt <= '0;
      free_cnt <= DEF_MASK; valid_cnt <= '0; unseen_cnt <= '0; alloc_cnt <= '0;
    end else begin
      base <= n_base; mask <= n_mask;
      wc <= n_wc; wa <= n_wa; rd <= n_rd; rp <= n_rp;
      rsp_valid <= op_valid; rsp_fail <= n_fail; rsp_ofs <= n_ofs; rsp_cnt <= n_cnt;
      free_cnt   <= (n_rd - n_wa - PW'(1)) & n_mask;
      valid_cnt  <= (n_wc - n_rd) & n_mask;
      unseen_cnt <= (n_wc - n_rp) & n_mask;
      alloc_cnt  <= (n_wa - n_rd) & n_mask;
    end
  end

  // R2: committed data never exceeds what was allocated
  a_r2_valid_within_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    valid_cnt <= alloc_cnt);

  // R3/R4: a bulk grant never exceeds the request
  a_r3_grant_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_WR || op_code == OP_RD)) |=> rsp_cnt <= $past(req_cnt));

  // R6: commit moves the committed pointer by one multiframe
  a_r6_commit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_CMT) |=> wc == (($past(wc) + MF) & mask));

  // R10: a failure only answers a reserve or peek
  a_r10_fail_source: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fail |-> rsp_valid && (($past(op_code) == OP_RSV) || ($past(op_code) == OP_PEEK)));

  // R10: a refused claim leaves the counts unchanged
  a_r10_fail_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fail |-> $stable(alloc_cnt) && $stable(unseen_cnt) && $stable(free_cnt));
endmodule

// File: tb/tb_frame_ring_ctl.sv
module tb_frame_ring_ctl;
  localparam int PW = 10;
  logic clk = 0, rst_n = 0, op_valid = 0;
  logic [2:0] op_code = '0;
  logic [PW:0] req_cnt = '0;
  logic [15:0] cfg_base = '0;
  logic [3:0] cfg_lg = '0;
  logic rsp_valid, rsp_fail;
  logic [15:0] rsp_ofs;
  logic [PW:0] rsp_cnt;
  logic [PW-1:0] free_cnt, valid_cnt, unseen_cnt, alloc_cnt;
  int checks = 0, errs = 0;

  always #5 clk = ~clk;

  frame_ring_ctl dut (.clk, .rst_n, .op_valid, .op_code, .req_cnt, .cfg_base, .cfg_lg,
    .rsp_valid, .rsp_fail, .rsp_ofs, .rsp_cnt, .free_cnt, .valid_cnt, .unseen_cnt, .alloc_cnt);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic counts(input string tag, input int f, input int v, input int u, input int a);
    chk({tag, " free"}, int'(free_cnt), f);
    chk({tag, " valid"}, int'(valid_cnt), v);
    chk({tag, " unseen"}, int'(unseen_cnt), u);
    chk({tag, " alloc"}, int'(alloc_cnt), a);
  endtask

  task automatic op(input logic [2:0] c, input int n);
    @(negedge clk);
    op_valid = 1; op_code = c; req_cnt = (PW+1)'(n);
    @(negedge clk);
    op_valid = 0;
  endtask

  task automatic rsp(input string tag, input int ofs, input int cnt, input int fail);
    chk({tag, " rsp_valid"}, int'(rsp_valid), 1);
    chk({tag, " ofs"}, int'(rsp_ofs), ofs);
    chk({tag, " cnt"}, int'(rsp_cnt), cnt);
    chk({tag, " fail"}, int'(rsp_fail), fail);
  endtask

  task automatic t_reset;
    counts("R1 reset", 127, 0, 0, 0);
    chk("R1 reset rsp_valid", int'(rsp_valid), 0);
  endtask

  task automatic t_init;
    cfg_base = 16'h100; cfg_lg = 4'd5;
    op(3'd0, 0);
    counts("R11 init", 31, 0, 0, 0);
  endtask

  task automatic t_bulk;
    op(3'd2, 10); rsp("R3 write", 'h100, 10, 0); counts("R3/R2 write", 21, 10, 10, 10);
    op(3'd3, 4);  rsp("R4 read", 'h100, 4, 0);   counts("R4/R2 read", 25, 6, 6, 6);
    op(3'd2, 40); rsp("R3 wrap clip", 'h10A, 22, 0); counts("R3 wrap", 3, 28, 28, 28);
    op(3'd3, 50); rsp("R4 clip", 'h104, 28, 0);  counts("R4 clip", 31, 0, 0, 0);
    op(3'd3, 5);  rsp("R4 empty", 'h100, 0, 0);  counts("R4 empty", 31, 0, 0, 0);
  endtask

  task automatic t_split;
    op(3'd4, 0); rsp("R5 reserve", 'h100, 16, 0); counts("R5 reserve", 15, 0, 0, 16);
    op(3'd4, 0); rsp("R10 reserve fail", 0, 0, 1); counts("R10 reserve fail", 15, 0, 0, 16);
    @(negedge clk);
    chk("R10 fail one cycle", int'(rsp_fail), 0);
    op(3'd5, 0); counts("R6 commit", 15, 16, 16, 16);
    op(3'd6, 0); rsp("R7 peek", 'h100, 16, 0); counts("R7 peek", 15, 16, 0, 16);
    op(3'd6, 0); rsp("R10 peek fail", 0, 0, 1); counts("R10 peek fail", 15, 16, 0, 16);
    op(3'd7, 0); counts("R8 discard", 31, 0, 0, 0);
  endtask

  task automatic t_flush;
    op(3'd2, 5); rsp("R3 write2", 'h110, 5, 0); counts("R3 write2", 26, 5, 5, 5);
    op(3'd3, 3); rsp("R4 read2", 'h110, 3, 0);  counts("R4 read2", 29, 2, 2, 2);
    op(3'd1, 0); counts("R9 flush", 26, 5, 5, 5);
    op(3'd3, 31); rsp("R9 flush read ptr", 'h110, 5, 0);
  endtask

  task automatic t_reinit;
    cfg_base = 16'h0; cfg_lg = 4'd7;
    op(3'd0, 0);
    counts("R11 reinit", 127, 0, 0, 0);
  endtask

  initial begin
    fork
      begin
        #25 rst_n = 1;
        @(negedge clk);
        t_reset(); t_init(); t_bulk(); t_split(); t_flush(); t_reinit();
      end
      begin
        repeat (5000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end
endmodule